// File: doc/BRIEF.md
# USB Device Enumeration State Controller

This block follows a USB device through enumeration on the device side: powered after attach, default after the first bus reset, address once a function address is in force, and configured once software has accepted a configuration. It takes event pulses from the line monitor and the endpoint 0 logic: the end of a bus reset, and the completion of a status IN handshake. It also takes simple register-style write strobes from software. From these it drives the current state, the address the packet decoder should match, and per-endpoint enable and type vectors. It also provides an end-of-reset status flag with a maskable interrupt line.

A new function address is first held as pending. It becomes active only after two things have happened: the status IN stage of the set-address transfer has completed, and software has cleared the resulting transmit-complete indication. The enables of the non-control endpoints follow the state. They can only be set in the configured state, and they are dropped as soon as the device leaves it.

Top module: `usb_enum_ctrl`

## Requirements
- R1: After reset the state is powered (code 0). The active address is 0, address matching is off, all endpoints are disabled, and the end-of-reset flag and interrupt are low. Every software write (global, address, endpoint) is ignored while powered.
- R2: A `busResetDone` pulse moves the state to default (code 1) and sets `endResetFlag`, both visible after the capturing clock edge.
- R3: `irq` is high exactly while `endResetFlag` and the stored mask bit are both set. `irqClr` clears the flag. The mask survives a bus reset.
- R4: Writes to endpoint 0 take effect in any state except powered. Writes to endpoints 1 and up are ignored unless the state is configured.
- R5: An address write is held as pending. `activeAddr` and `addrMatchEn` change only at the edge where `txCompClr` clears a transmit-complete indication that was set by `statusInDone`. Clearing without a prior `statusInDone` commits nothing.
- R6: The state becomes address (code 2) one cycle after both the address-enabled flag is set and an address with function-enable 1 has been committed. Either one alone leaves the state at default.
- R7: A global write that requests the configured flag is ignored unless the state is already address or configured. When accepted, the state becomes configured (code 3) on the following cycle.
- R8: Writing the configured flag to 0 returns the state to address. At the same edge, the enables and types of endpoints 1 and up are cleared.
- R9: A bus reset in any state does the following: it returns the state to default, zeroes the address and the function-enable bit, clears the address-enabled and configured flags, and disables endpoints 1 and up while keeping endpoint 0. It also discards a pending address and any transmit-complete indication.
- R10: While the committed function-enable bit is 0, `activeAddr` reads 0 and `addrMatchEn` is low, whatever 7-bit value was committed.
- R11: Endpoint type is 2 bits per endpoint: 0 control, 1 isochronous, 2 bulk, 3 interrupt. Endpoint i occupies bits [2i+1:2i] of `epTypes`. A disabled endpoint's field reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; models attach (powered state) |
| busResetDone | input | 1 | Pulse: end of bus reset detected |
| statusInDone | input | 1 | Pulse: endpoint 0 status IN handshake completed |
| txCompClr | input | 1 | Software clears the endpoint 0 transmit-complete indication |
| glbWr | input | 1 | Global state write strobe |
| glbAddrEn | input | 1 | Address-enabled flag value for a global write |
| glbConfig | input | 1 | Configured flag value for a global write |
| faddrWr | input | 1 | Function address write strobe |
| faddrFen | input | 1 | Function-enable bit of the address write |
| faddrVal | input | 7 | Function address value |
| epWr | input | 1 | Endpoint control write strobe |
| epIdx | input | clog2(NUM_EP) | Endpoint selected by the write |
| epEnable | input | 1 | Enable value for the selected endpoint |
| epType | input | 2 | Type value for the selected endpoint |
| irqMaskWr | input | 1 | Interrupt mask write strobe |
| irqMaskVal | input | 1 | Mask value for the end-of-reset flag |
| irqClr | input | 1 | Clears the end-of-reset flag |
| devState | output | 2 | Current state code |
| activeAddr | output | 7 | Address the packet decoder matches |
| addrMatchEn | output | 1 | Committed function-enable bit |
| epEnables | output | NUM_EP | Per-endpoint enable |
| epTypes | output | 2*NUM_EP | Per-endpoint type, zero when disabled |
| endResetFlag | output | 1 | End-of-reset status flag |
| irq | output | 1 | Masked interrupt line |

## Verification
The hardest situation to reach is a bus reset that arrives while an address change is in flight. In that case a new address is pending and the transmit-complete indication is already set, with the device in the configured state and upper endpoints enabled. The stimulus first builds up the full configured state through the normal address and configuration sequence. It then writes a second address and pulses the status completion. Next it issues the bus reset, and after that it clears the transmit-complete indication. This shows that nothing stale gets committed. A second hard case is the cycle where the configured flag drops: upper endpoint enables must vanish on the same edge as the state change.

// File: rtl/usb_enum_pkg.sv
package usb_enum_pkg;

  localparam int ADDR_W = 7;
  localparam int TYPE_W = 2;

  typedef enum logic [1:0] {
    ST_POWERED = 2'd0,
    ST_DEFAULT = 2'd1,
    ST_ADDRESS = 2'd2,
    ST_CONFIG  = 2'd3
  } devState_t;

  // Strobes from the control FSM to the register datapath
  typedef struct packed {
    logic busRst;
    logic glbLoad;
    logic cfgAllow;
    logic faddrLoad;
    logic commit;
    logic ep0Load;
    logic epHiLoad;
    logic dropHi;
  } ctrlStrobe_t;

endpackage

// File: rtl/usb_enum_fsm.sv
module usb_enum_fsm
  import usb_enum_pkg::*;
#(
  parameter int NUM_EP = 4,
  localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           busResetDone,
  input  logic           statusInDone,
  input  logic           txCompClr,
  input  logic           glbWr,
  input  logic           faddrWr,
  input  logic           epWr,
  input  logic [EPW-1:0] epIdx,
  input  logic           addrEnQ,
  input  logic           fenQ,
  input  logic           cfgQ,
  input  logic           pendValidQ,
  output devState_t      stateQ,
  output ctrlStrobe_t    strobe
);

  devState_t stateD;
  logic      txCompQ;
  logic      live;
  logic      isIdx0;

  assign live   = (stateQ != ST_POWERED);
  assign isIdx0 = (epIdx == '0);

  always_comb begin
    strobe.busRst    = busResetDone;
    strobe.glbLoad   = glbWr && live && !busResetDone;
    strobe.cfgAllow  = (stateQ == ST_ADDRESS) || (stateQ == ST_CONFIG);
    strobe.faddrLoad = faddrWr && live && !busResetDone;
    strobe.commit    = txCompClr && txCompQ && pendValidQ && !busResetDone;
    strobe.ep0Load   = epWr && live && isIdx0 && !busResetDone;
    strobe.epHiLoad  = epWr && !isIdx0 && (stateQ == ST_CONFIG) && cfgQ && !busResetDone;
    strobe.dropHi    = busResetDone || ((stateQ == ST_CONFIG) && !cfgQ);
  end

  always_comb begin
    stateD = stateQ;
    if (busResetDone) begin
      stateD = ST_DEFAULT;
    end else if (live) begin
      if (cfgQ)                stateD = ST_CONFIG;
      else if (addrEnQ && fenQ) stateD = ST_ADDRESS;
      else                      stateD = ST_DEFAULT;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_POWERED;
      txCompQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (busResetDone)      txCompQ <= 1'b0;
      else if (statusInDone) txCompQ <= 1'b1;
      else if (txCompClr)    txCompQ <= 1'b0;
    end
  end

endmodule

// File: rtl/usb_enum_regs.sv
module usb_enum_regs
  import usb_enum_pkg::*;
#(
  parameter int NUM_EP = 4,
  localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strobe,
  input  logic                   glbAddrEn,
  input  logic                   glbConfig,
  input  logic                   faddrFen,
  input  logic [ADDR_W-1:0]      faddrVal,
  input  logic [EPW-1:0]         epIdx,
  input  logic                   epEnable,
  input  logic [TYPE_W-1:0]      epType,
  input  logic                   irqMaskWr,
  input  logic                   irqMaskVal,
  input  logic                   irqClr,
  output logic                   addrEnQ,
  output logic                   cfgQ,
  output logic                   fenQ,
  output logic                   pendValidQ,
  output logic [ADDR_W-1:0]      activeAddr,
  output logic                   addrMatchEn,
  output logic [NUM_EP-1:0]      epEnables,
  output logic [TYPE_W*NUM_EP-1:0] epTypes,
  output logic                   endResetFlag,
  output logic                   irq
);

  logic [ADDR_W-1:0] funcAddrQ;
  logic [ADDR_W-1:0] pendAddrQ;
  logic              pendFenQ;
  logic              maskQ;

  // Global flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrEnQ <= 1'b0;
      cfgQ    <= 1'b0;
    end else if (strobe.busRst) begin
      addrEnQ <= 1'b0;
      cfgQ    <= 1'b0;
    end else if (strobe.glbLoad) begin
      addrEnQ <= glbAddrEn;
      cfgQ    <= glbConfig && glbAddrEn && strobe.cfgAllow;
    end
  end

  // Pending and committed function address
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAddrQ  <= '0;
      pendFenQ   <= 1'b0;
      pendValidQ <= 1'b0;
      funcAddrQ  <= '0;
      fenQ       <= 1'b0;
    end else if (strobe.busRst) begin
      pendValidQ <= 1'b0;
      funcAddrQ  <= '0;
      fenQ       <= 1'b0;
    end else begin
      if (strobe.commit) begin
        funcAddrQ  <= pendAddrQ;
        fenQ       <= pendFenQ;
        pendValidQ <= 1'b0;
      end
      if (strobe.faddrLoad) begin
        pendAddrQ  <= faddrVal;
        pendFenQ   <= faddrFen;
        pendValidQ <= 1'b1;
      end
    end
  end

  assign activeAddr  = fenQ ? funcAddrQ : '0;
  assign addrMatchEn = fenQ;

  // End-of-reset flag and mask
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      endResetFlag <= 1'b0;
      maskQ        <= 1'b0;
    end else begin
      if (strobe.busRst) endResetFlag <= 1'b1;
      else if (irqClr)   endResetFlag <= 1'b0;
      if (irqMaskWr)     maskQ        <= irqMaskVal;
    end
  end

  assign irq = endResetFlag && maskQ;

  // Per-endpoint enable and type
  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    logic              enQ;
    logic [TYPE_W-1:0] typeQ;
    if (i == 0) begin : g_ctl
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          enQ   <= 1'b0;
          typeQ <= '0;
        end else if (strobe.ep0Load) begin
          enQ   <= epEnable;
          typeQ <= epType;
        end
      end
    end else begin : g_hi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          enQ   <= 1'b0;
          typeQ <= '0;
        end else if (strobe.dropHi) begin
          enQ   <= 1'b0;
          typeQ <= '0;
        end else if (strobe.epHiLoad && (epIdx == EPW'(i))) begin
          enQ   <= epEnable;
          typeQ <= epType;
        end
      end
    end
    assign epEnables[i] = enQ;
    assign epTypes[TYPE_W*i +: TYPE_W] = enQ ? typeQ : '0;
  end

endmodule

// File: rtl/usb_enum_ctrl.sv
module usb_enum_ctrl
  import usb_enum_pkg::*;
#(
  parameter int NUM_EP = 4,
  localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busResetDone,
  input  logic                     statusInDone,
  input  logic                     txCompClr,
  input  logic                     glbWr,
  input  logic                     glbAddrEn,
  input  logic                     glbConfig,
  input  logic                     faddrWr,
  input  logic                     faddrFen,
  input  logic [ADDR_W-1:0]        faddrVal,
  input  logic                     epWr,
  input  logic [EPW-1:0]           epIdx,
  input  logic                     epEnable,
  input  logic [TYPE_W-1:0]        epType,
  input  logic                     irqMaskWr,
  input  logic                     irqMaskVal,
  input  logic                     irqClr,
  output logic [1:0]               devState,
  output logic [ADDR_W-1:0]        activeAddr,
  output logic                     addrMatchEn,
  output logic [NUM_EP-1:0]        epEnables,
  output logic [TYPE_W*NUM_EP-1:0] epTypes,
  output logic                     endResetFlag,
  output logic                     irq
);

  devState_t   stateQ;
  ctrlStrobe_t strobe;
  logic        addrEnQ;
  logic        cfgQ;
  logic        fenQ;
  logic        pendValidQ;

  usb_enum_fsm #(.NUM_EP(NUM_EP)) u_fsm (
    .clk          (clk),
    .rstN         (rstN),
    .busResetDone (busResetDone),
    .statusInDone (statusInDone),
    .txCompClr    (txCompClr),
    .glbWr        (glbWr),
    .faddrWr      (faddrWr),
    .epWr         (epWr),
    .epIdx        (epIdx),
    .addrEnQ      (addrEnQ),
    .fenQ         (fenQ),
    .cfgQ         (cfgQ),
    .pendValidQ   (pendValidQ),
    .stateQ       (stateQ),
    .strobe       (strobe)
  );

  usb_enum_regs #(.NUM_EP(NUM_EP)) u_regs (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .glbAddrEn    (glbAddrEn),
    .glbConfig    (glbConfig),
    .faddrFen     (faddrFen),
    .faddrVal     (faddrVal),
    .epIdx        (epIdx),
    .epEnable     (epEnable),
    .epType       (epType),
    .irqMaskWr    (irqMaskWr),
    .irqMaskVal   (irqMaskVal),
    .irqClr       (irqClr),
    .addrEnQ      (addrEnQ),
    .cfgQ         (cfgQ),
    .fenQ         (fenQ),
    .pendValidQ   (pendValidQ),
    .activeAddr   (activeAddr),
    .addrMatchEn  (addrMatchEn),
    .epEnables    (epEnables),
    .epTypes      (epTypes),
    .endResetFlag (endResetFlag),
    .irq          (irq)
  );

  assign devState = stateQ;

endmodule

// File: rtl/usb_enum_chk.sv
module usb_enum_chk
  import usb_enum_pkg::*;
#(
  parameter int NUM_EP = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busResetDone,
  input logic              txCompClr,
  input logic [1:0]        devState,
  input logic [ADDR_W-1:0] activeAddr,
  input logic              addrMatchEn,
  input logic [NUM_EP-1:0] epEnables,
  input logic              endResetFlag,
  input logic              irq
);

  assert_powered_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (devState == 2'd0) |-> (epEnables == '0 && !addrMatchEn && !endResetFlag));

  assert_flag_source_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(endResetFlag) |-> $past(busResetDone));

  assert_irq_needs_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> endResetFlag);

  assert_addr_commit_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeAddr) |-> ($past(txCompClr) || $past(busResetDone)));

  assert_config_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(devState == 2'd3) |-> ($past(devState) == 2'd2));

  assert_bus_reset_R9: assert property (@(posedge clk) disable iff (!rstN)
    busResetDone |=> (devState == 2'd1 && activeAddr == '0 && !addrMatchEn));

  if (NUM_EP > 1) begin : g_hi
    assert_hi_ep_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
      (devState != 2'd3) |-> (epEnables[NUM_EP-1:1] == '0));
  end

endmodule

bind usb_enum_ctrl usb_enum_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .busResetDone (busResetDone),
  .txCompClr    (txCompClr),
  .devState     (devState),
  .activeAddr   (activeAddr),
  .addrMatchEn  (addrMatchEn),
  .epEnables    (epEnables),
  .endResetFlag (endResetFlag),
  .irq          (irq)
);

// File: tb/usb_enum_ctrl_tb.sv
module usb_enum_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_EP = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busResetDone = 1'b0;
  logic       statusInDone = 1'b0;
  logic       txCompClr = 1'b0;
  logic       glbWr = 1'b0;
  logic       glbAddrEn = 1'b0;
  logic       glbConfig = 1'b0;
  logic       faddrWr = 1'b0;
  logic       faddrFen = 1'b0;
  logic [6:0] faddrVal = '0;
  logic       epWr = 1'b0;
  logic [1:0] epIdx = '0;
  logic       epEnable = 1'b0;
  logic [1:0] epType = '0;
  logic       irqMaskWr = 1'b0;
  logic       irqMaskVal = 1'b0;
  logic       irqClr = 1'b0;
  logic [1:0] devState;
  logic [6:0] activeAddr;
  logic       addrMatchEn;
  logic [3:0] epEnables;
  logic [7:0] epTypes;
  logic       endResetFlag;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_enum_ctrl #(.NUM_EP(NUM_EP)) u_dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic pulseBusReset(); busResetDone = 1; tick(); busResetDone = 0; endtask
  task automatic pulseStatus();   statusInDone = 1; tick(); statusInDone = 0; endtask
  task automatic pulseTxClr();    txCompClr = 1;    tick(); txCompClr = 0;    endtask

  task automatic writeGlb(input logic ae, input logic cf);
    glbWr = 1; glbAddrEn = ae; glbConfig = cf; tick(); glbWr = 0;
  endtask

  task automatic writeAddr(input logic fen, input logic [6:0] a);
    faddrWr = 1; faddrFen = fen; faddrVal = a; tick(); faddrWr = 0;
  endtask

  task automatic writeEp(input logic [1:0] idx, input logic en, input logic [1:0] ty);
    epWr = 1; epIdx = idx; epEnable = en; epType = ty; tick(); epWr = 0;
  endtask

  task automatic setAddress(input logic fen, input logic [6:0] a);
    writeAddr(fen, a); pulseStatus(); pulseTxClr();
  endtask

  task automatic test_reset();
    check("R1 state", devState, 0);
    check("R1 addr", activeAddr, 0);
    check("R1 match", addrMatchEn, 0);
    check("R1 eps", epEnables, 0);
    check("R1 flag", endResetFlag, 0);
    check("R1 irq", irq, 0);
    writeEp(0, 1, 0);
    writeGlb(1, 0);
    tick();
    check("R1 ep write ignored", epEnables, 0);
    check("R1 state after writes", devState, 0);
  endtask

  task automatic test_bus_reset_entry();
    pulseBusReset();
    check("R2 state default", devState, 1);
    check("R2 flag", endResetFlag, 1);
    check("R3 masked irq", irq, 0);
    irqMaskWr = 1; irqMaskVal = 1; tick(); irqMaskWr = 0;
    check("R3 unmasked irq", irq, 1);
    irqClr = 1; tick(); irqClr = 0;
    check("R3 flag cleared", endResetFlag, 0);
    check("R3 irq cleared", irq, 0);
  endtask

  task automatic test_ep0();
    writeEp(0, 1, 0);
    check("R4 ep0 enabled", epEnables, 4'b0001);
    writeEp(1, 1, 2);
    check("R4 ep1 ignored in default", epEnables, 4'b0001);
  endtask

  task automatic test_address();
    writeAddr(1, 7'h2A);
    check("R5 pending addr", activeAddr, 0);
    check("R5 pending match", addrMatchEn, 0);
    pulseTxClr();
    check("R5 clear w/o status", activeAddr, 0);
    pulseStatus();
    check("R5 status only", activeAddr, 0);
    pulseTxClr();
    check("R5 committed addr", activeAddr, 7'h2A);
    check("R5 committed match", addrMatchEn, 1);
    tick();
    check("R6 no addrEn yet", devState, 1);
    writeGlb(1, 1);
    tick();
    check("R6 address state", devState, 2);
    tick();
    check("R7 cfg ignored in default", devState, 2);
  endtask

  task automatic test_config();
    writeGlb(1, 1);
    tick();
    check("R7 configured", devState, 3);
    writeEp(1, 1, 2);
    writeEp(3, 1, 3);
    writeEp(2, 0, 1);
    check("R4 upper eps", epEnables, 4'b1011);
    check("R11 types", epTypes, 8'hC8);
  endtask

  task automatic test_unconfig();
    writeGlb(1, 0);
    tick();
    check("R8 back to address", devState, 2);
    check("R8 upper eps dropped", epEnables, 4'b0001);
    check("R8 types dropped", epTypes, 8'h00);
  endtask

  task automatic test_fen_zero();
    setAddress(0, 7'h15);
    check("R10 addr zero", activeAddr, 0);
    check("R10 match off", addrMatchEn, 0);
    tick();
    check("R10 state default", devState, 1);
  endtask

  task automatic test_bus_reset_any();
    setAddress(1, 7'h33);
    tick();
    check("R9 setup address", devState, 2);
    writeGlb(1, 1);
    tick();
    check("R9 setup configured", devState, 3);
    writeEp(2, 1, 2);
    check("R9 setup ep2", epEnables, 4'b0101);
    writeAddr(1, 7'h44);
    pulseStatus();
    pulseBusReset();
    check("R9 state", devState, 1);
    check("R9 addr", activeAddr, 0);
    check("R9 match", addrMatchEn, 0);
    check("R9 eps", epEnables, 4'b0001);
    check("R9 flag", endResetFlag, 1);
    check("R3 mask kept", irq, 1);
    pulseTxClr();
    check("R9 pending dropped", activeAddr, 0);
    writeGlb(1, 0);
    tick();
    check("R9 fen cleared", devState, 1);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    test_reset();
    test_bus_reset_entry();
    test_ep0();
    test_address();
    test_config();
    test_unconfig();
    test_fen_zero();
    test_bus_reset_any();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule